// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-beat requests from a processor core into cycles on an external 8-bit bus. On that bus the low address byte and the data byte share one port, and the high address byte has a port of its own. A request gives a 16-bit address, a kind (data read, data write or instruction fetch) and write data. The block runs one bus cycle and then pulses `done` for one period. For reads and fetches, the returned byte appears on `rdata` during that same period. Every period of `clk` is one oscillator period.

A bus cycle moves through five named states. ST_IDLE waits for a request. The move ST_IDLE→ST_LATCH happens on the edge that accepts a request. ST_LATCH holds the address-latch strobe high for LATCH_CYC periods while the low address byte is driven. ST_LATCH→ST_ADDR_HOLD follows the last latch period. ST_ADDR_HOLD keeps the low address on the port for one period with the latch strobe low. ST_ADDR_HOLD→ST_STROBE always follows. ST_STROBE holds exactly one access strobe low for STROBE_CYC periods, plus one period for each wait sample that is low. ST_STROBE→ST_RECOVER happens at the end of the strobe. ST_RECOVER holds write data and the high address for one more period and raises `done`. ST_RECOVER→ST_IDLE always follows. The separate fetch strobe is used for instruction fetches. When `code_internal` is high, fetch requests are treated as internal and produce no bus activity. The `float_sel` pin selects the strobe pin state while reset is held.

Top module: `mux_xbus_ctrl`

## Requirements
- R1: A request is accepted on a rising edge in ST_IDLE. For the next 3 periods, `ale` is 1, `ad_oe` is 1 and `ad_out` carries address bits 7:0.
- R2: In the one period after `ale` falls, `ad_out` still carries address bits 7:0 with `ad_oe`=1, and `fetch_n`, `rd_n` and `wr_n` are all 1.
- R3: The access strobe is low for 4 periods, starting 2 periods after `ale` falls. The kind selects it: `req_kind` 0 (read) uses `rd_n`, 1 (write) uses `wr_n`, and 2 (fetch) uses `fetch_n`. At most one strobe is ever low, and none is low while `ale` is 1.
- R4: `wait_n` is sampled on the edge that ends the last nominal strobe period, and on each later strobe edge. Each low sample adds one period to the strobe.
- R5: For reads and fetches, `ad_oe` is 0 throughout the strobe. The `ad_in` value present at the edge where the strobe rises is returned on `rdata` in the following period. `done` is 1 for exactly that one period.
- R6: For writes, `ad_out` carries the write data with `ad_oe`=1 during the whole strobe and for one period after it. `done` is 1 in that one period after.
- R7: `addr_hi` carries address bits 15:8 from the first `ale` period until the end of the `done` period.
- R8: A fetch request while `code_internal` is 1, or any request with `req_kind` 3, is ignored. `ale` stays 0, all strobes stay 1 and no `done` follows.
- R9: Requests presented while a cycle is in progress are ignored. The running cycle finishes with its own address and data.
- R10: While `rst_n` is 0, `ale`, `fetch_n`, `rd_n` and `wr_n` are 1, `ad_oe` and `done` are 0, and `strobe_oe` follows `float_sel`. After reset `strobe_oe` is 1, `ale` is 0 and all strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| float_sel | input | 1 | Strobe pin policy during reset: 1 drive high, 0 float |
| code_internal | input | 1 | 1: fetches are internal and no bus cycle is run |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-period completion pulse |
| rdata | output | 8 | Read or fetch data, valid with `done` |
| ad_out | output | 8 | Shared port output value (low address or write data) |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| addr_hi | output | 8 | High address byte port |
| ale | output | 1 | Address-latch strobe, active high |
| fetch_n | output | 1 | Program-fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| strobe_oe | output | 1 | Output enable for the four strobes |
| wait_n | input | 1 | Wait request, active low |

## Verification
The bench builds the controller with its default widths and the 3-period latch and 4-period strobe phases. Because of that, every expected period of each state can be listed outright. Wait counts from zero to three reach both the unstretched path and the saturated strobe counter that holds through repeated low samples. Random 16-bit addresses, including all-ones and zero, and random data with inverted decoys on the shared input cover capture timing, port release and request rejection.

// File: rtl/mux_xbus_pkg.sv
package mux_xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LATCH     = 3'd1,
        ST_ADDR_HOLD = 3'd2,
        ST_STROBE    = 3'd3,
        ST_RECOVER   = 3'd4
    } xbus_state_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } xbus_kind_e;

endpackage

// File: rtl/mux_xbus_fsm.sv
module mux_xbus_fsm
    import mux_xbus_pkg::*;
#(
    parameter int LATCH_CYC  = 3,
    parameter int STROBE_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wait_n,
    output xbus_state_e state,
    output logic        strobe_end
);
    localparam int MAX_CYC = (LATCH_CYC > STROBE_CYC) ? LATCH_CYC : STROBE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] LATCH_LAST  = CNT_W'(LATCH_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);

    xbus_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        strobe_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LATCH;
                    cnt_d   = '0;
                end
            end
            ST_LATCH: begin
                if (cnt_q == LATCH_LAST) begin
                    state_d = ST_ADDR_HOLD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ADDR_HOLD: begin
                state_d = ST_STROBE;
                cnt_d   = '0;
            end
            ST_STROBE: begin
                if (cnt_q != STROBE_LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end else if (wait_n) begin
                    state_d    = ST_RECOVER;
                    strobe_end = 1'b1;
                end
            end
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && cnt_q != LATCH_LAST) |=> state_q == ST_LATCH); // R1
    AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && cnt_q != STROBE_LAST) |=> state_q == ST_STROBE); // R3
    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && cnt_q == STROBE_LAST && !wait_n) |=> state_q == ST_STROBE); // R4
    AST_HOLD_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HOLD) |=> state_q == ST_STROBE); // R2

endmodule

// File: rtl/mux_xbus_capture.sv
module mux_xbus_capture
    import mux_xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  xbus_kind_e        kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              strobe_end,
    input  logic [DATA_W-1:0] ad_in,
    output xbus_kind_e        kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind_in;
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (strobe_end && kind_q != KIND_WRITE) begin
                rdata_q <= ad_in;
            end
        end
    end

    AST_NO_CAPTURE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_end |-> !accept); // R9

endmodule

// File: rtl/mux_xbus_pins.sv
module mux_xbus_pins
    import mux_xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              float_sel,
    input  xbus_state_e       state,
    input  xbus_kind_e        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale,
    output logic              fetch_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              strobe_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              done
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic addr_phase, strobe_phase, write_kind;

    always_comb begin
        addr_phase   = (state == ST_LATCH) || (state == ST_ADDR_HOLD);
        strobe_phase = (state == ST_STROBE);
        write_kind   = (kind == KIND_WRITE);
        addr_hi      = addr[ADDR_W-1 -: HI_W];
        done         = rst_n && (state == ST_RECOVER);
        if (!rst_n) begin
            ale       = 1'b1;
            fetch_n   = 1'b1;
            rd_n      = 1'b1;
            wr_n      = 1'b1;
            strobe_oe = float_sel;
            ad_oe     = 1'b0;
            ad_out    = '0;
        end else begin
            ale       = (state == ST_LATCH);
            fetch_n   = !(strobe_phase && kind == KIND_FETCH);
            rd_n      = !(strobe_phase && kind == KIND_READ);
            wr_n      = !(strobe_phase && write_kind);
            strobe_oe = 1'b1;
            if (addr_phase) begin
                ad_oe  = 1'b1;
                ad_out = addr[DATA_W-1:0];
            end else if (write_kind && (strobe_phase || state == ST_RECOVER)) begin
                ad_oe  = 1'b1;
                ad_out = wdata;
            end else begin
                ad_oe  = 1'b0;
                ad_out = '0;
            end
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_PINS: assert (ale && fetch_n && rd_n && wr_n && !ad_oe && !done); // R10
        end
    end

    AST_ALE_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe); // R1
    AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (fetch_n && rd_n && wr_n)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~fetch_n, ~rd_n, ~wr_n}) <= 1); // R3
    AST_READ_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !fetch_n) |-> !ad_oe); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_WRITE_PORT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R6
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && (!fetch_n || !rd_n || !wr_n)) |-> $stable(addr_hi)); // R7

endmodule

// File: rtl/mux_xbus_ctrl.sv
module mux_xbus_ctrl
    import mux_xbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LATCH_CYC  = 3,
    parameter int STROBE_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     float_sel,
    input  logic                     code_internal,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     fetch_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     strobe_oe,
    input  logic                     wait_n
);
    xbus_state_e       state;
    xbus_kind_e        kind_in, kind_q;
    logic              accept, strobe_end, legal;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_comb begin
        kind_in = xbus_kind_e'(req_kind);
        unique case (kind_in)
            KIND_READ, KIND_WRITE: legal = 1'b1;
            KIND_FETCH:            legal = !code_internal;
            default:               legal = 1'b0;
        endcase
        accept = (state == ST_IDLE) && req_valid && legal;
    end

    mux_xbus_fsm #(
        .LATCH_CYC (LATCH_CYC),
        .STROBE_CYC(STROBE_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .wait_n    (wait_n),
        .state     (state),
        .strobe_end(strobe_end)
    );

    mux_xbus_capture #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .kind_in   (kind_in),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .strobe_end(strobe_end),
        .ad_in     (ad_in),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata)
    );

    mux_xbus_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) pins_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .float_sel(float_sel),
        .state    (state),
        .kind     (kind_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .ale      (ale),
        .fetch_n  (fetch_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .strobe_oe(strobe_oe),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .addr_hi  (addr_hi),
        .done     (done)
    );

    AST_INTERNAL_FETCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_kind == 2'd2 && code_internal) |=> !ale); // R8
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_kind == 2'd3) |=> !ale); // R8

endmodule

// File: tb/mux_xbus_ctrl_tb_top.sv
module mux_xbus_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       float_sel = 1'b1;
    logic       code_internal = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       done;
    logic [7:0] rdata, ad_out, addr_hi;
    logic       ad_oe, ale, fetch_n, rd_n, wr_n, strobe_oe;
    logic [7:0] ad_in = '0;
    logic       wait_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mux_xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .float_sel(float_sel), .code_internal(code_internal),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi), .ale(ale), .fetch_n(fetch_n), .rd_n(rd_n), .wr_n(wr_n),
        .strobe_oe(strobe_oe), .wait_n(wait_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_strobe(input int p, input int waits, input int kind, input int which);
        return (p >= 4) && (p < 8 + waits) && (kind == which);
    endfunction

    task automatic idle_pins(input string req);
        chk(ale == 1'b0, req, "ale idle", ale, 0);
        chk({fetch_n, rd_n, wr_n} == 3'b111, req, "strobes idle", {fetch_n, rd_n, wr_n}, 3'b111);
        chk(done == 1'b0, req, "done idle", done, 0);
    endtask

    task automatic run_txn(input int kind, input logic [15:0] addr, input logic [7:0] wdata,
                           input logic [7:0] rdval, input int waits, input bit spam);
        int total;
        string st;
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = kind[1:0]; req_addr = addr; req_wdata = wdata;
        wait_n = 1'b1; ad_in = ~rdval;
        @(posedge clk); #1;
        req_valid = spam;
        req_addr = ~addr; req_wdata = ~wdata;
        total = 9 + waits;
        st = (waits > 0) ? "R4" : "R3";
        for (int p = 0; p < total; p++) begin
            int s;
            bit latch, hold, strb, rec, oe;
            logic [7:0] ad_exp;
            if (p > 0) begin @(posedge clk); #1; end
            s = p - 4;
            wait_n = !(s >= 3 && s < 3 + waits);
            ad_in = (s >= 0 && s < 4 + waits) ? rdval : ~rdval;
            latch = (p < 3); hold = (p == 3);
            strb = (p >= 4) && (p < 8 + waits); rec = (p == 8 + waits);
            oe = latch || hold || ((strb || rec) && kind == 1);
            ad_exp = (latch || hold) ? addr[7:0] : wdata;
            @(negedge clk);
            chk(ale == latch, "R1", "ale", ale, latch);
            chk(rd_n == !exp_strobe(p, waits, kind, 0), st, "rd_n", rd_n, !exp_strobe(p, waits, kind, 0));
            chk(wr_n == !exp_strobe(p, waits, kind, 1), st, "wr_n", wr_n, !exp_strobe(p, waits, kind, 1));
            chk(fetch_n == !exp_strobe(p, waits, kind, 2), st, "fetch_n", fetch_n, !exp_strobe(p, waits, kind, 2));
            chk(ad_oe == oe, latch ? "R1" : hold ? "R2" : (kind == 1) ? "R6" : "R5", "ad_oe", ad_oe, oe);
            if (oe)
                chk(ad_out == ad_exp, latch ? "R1" : hold ? "R2" : spam ? "R9" : "R6", "ad_out", ad_out, ad_exp);
            chk(addr_hi == addr[15:8], spam ? "R9" : "R7", "addr_hi", addr_hi, addr[15:8]);
            chk(done == rec, (kind == 1) ? "R6" : "R5", "done", done, rec);
            if (rec && kind != 1)
                chk(rdata == rdval, "R5", "rdata", rdata, rdval);
        end
        req_valid = 1'b0; wait_n = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        idle_pins(spam ? "R9" : "R5");
    endtask

    task automatic ignored(input int kind, input bit internal);
        @(posedge clk); #1;
        code_internal = internal; req_valid = 1'b1; req_kind = kind[1:0]; req_addr = 16'h1234;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            idle_pins("R8");
            @(posedge clk); #1;
        end
        code_internal = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (2) @(negedge clk);
        chk(strobe_oe == 1'b1, "R10", "strobe_oe float_sel=1", strobe_oe, 1);
        chk({ale, fetch_n, rd_n, wr_n} == 4'hF, "R10", "strobes in reset", {ale, fetch_n, rd_n, wr_n}, 4'hF);
        chk(ad_oe == 1'b0 && done == 1'b0, "R10", "port in reset", {ad_oe, done}, 0);
        float_sel = 1'b0;
        #1;
        chk(strobe_oe == 1'b0, "R10", "strobe_oe float_sel=0", strobe_oe, 0);
        float_sel = 1'b1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(strobe_oe == 1'b1, "R10", "strobe_oe after reset", strobe_oe, 1);
        idle_pins("R10");

        run_txn(0, 16'hA55A, 8'h00, 8'h3C, 0, 0);
        run_txn(1, 16'h0F01, 8'hC3, 8'h00, 0, 0);
        run_txn(2, 16'hFFFF, 8'h00, 8'h00, 2, 0);
        run_txn(1, 16'h0000, 8'hFF, 8'h5A, 3, 1);
        run_txn(0, 16'h8001, 8'h00, 8'hFF, 1, 1);
        ignored(2, 1);
        ignored(3, 0);
        run_txn(2, 16'h1357, 8'h00, 8'h96, 0, 0);

        for (int i = 0; i < 40; i++) begin
            int k;
            k = int'($urandom_range(2, 0));
            run_txn(k, 16'($urandom), 8'($urandom), 8'($urandom),
                    int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule